// File: doc/BRIEF.md
# USB Device Power-Mode Control Register

This block is the byte-wide power-mode control register of a high-speed USB peripheral. A local processor writes and reads it over a 16-bit bus. Three of its bits are commands: suspend entry, upstream resume and soft reset. A command acts only when a one held in the bit is overwritten by a zero. The other bits are persistent enables: clocks kept running in suspend, the global interrupt enable, wake-up on chip select, and connection of the D+ pull-up.

All delays are counted in pulses of a one-millisecond tick input, so the timed actions need no fast counters:
- After suspend is entered, the clock enable drops once a short delay has passed, unless clocks are kept on.
- A resume command waits, then drives upstream resume signalling for a fixed time.
- Wake-up through chip select and the start of resume signalling both leave suspend and restore the clock at once.

A USB bus reset clears the command and wake bits but keeps the clock-keep, interrupt-enable and pull-up bits. A soft reset gives a one-cycle pulse and returns the whole block to its hardware-reset state.

Top module: `usb_pwr_mode_reg`

## Requirements
- R1: After hardware reset every register bit is zero, `clk_en` is 1, and `suspended`, `resume_drive`, `soft_rst_pulse`, `irq_en`, `pullup_en` and `wake_evt` are 0.
- R2: A write stores `wr_data[7:0]` and ignores `wr_data[15:8]`. The bits are: 7 clock keep, 6 resume command, 5 suspend command, 4 soft-reset command, 3 global interrupt enable, 2 chip-select wake enable, 1 reserved, 0 pull-up enable. While `rd_en` is high, `rd_data[7:0]` shows the stored bits, with bit 1 always 0 and `rd_data[15:8]` always 0.
- R3: A command bit (6, 5 or 4) acts only on a write that puts a 0 into the bit while the stored value is 1. Writing 0 over 0, or writing 1, has no effect.
- R4: A suspend command sets `suspended` in the cycle after the write.
- R5: With bit 7 at 0, `clk_en` falls at the GATE_MS-th tick after suspend entry. With bit 7 at 1, `clk_en` stays 1 during suspend.
- R6: A resume command raises `resume_drive` at the RES_DELAY_MS-th tick. It holds it for RES_DRIVE_MS further ticks. At the moment it rises, `suspended` clears and `clk_en` returns to 1.
- R7: When the block is suspended, bit 2 is 1 and `cs_n` is low, `wake_evt` pulses for one cycle, `suspended` clears and `clk_en` returns to 1. When bit 2 is 0, a low `cs_n` has no effect.
- R8: A `bus_rst` cycle keeps bits 7, 3 and 0 and clears all the others. It also ends suspend and any running resume sequence.
- R9: A soft-reset command gives `soft_rst_pulse` high for exactly one cycle, the cycle after the write. At the next edge the register and all sequences return to their R1 state.
- R10: `irq_en` follows bit 3 and `pullup_en` follows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_rst | input | 1 | USB bus reset indication, synchronous |
| cs_n | input | 1 | Chip select, active low |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data (low byte used) |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data |
| clk_en | output | 1 | Internal clock enable |
| suspended | output | 1 | Device is in suspend |
| resume_drive | output | 1 | Drive upstream resume signalling |
| soft_rst_pulse | output | 1 | One-cycle software reset pulse |
| irq_en | output | 1 | Global interrupt enable |
| pullup_en | output | 1 | D+ pull-up connect |
| wake_evt | output | 1 | One-cycle wake-up event |

## Verification
The assertions take for granted that `bus_rst`, `wr_en` and `cs_n` are synchronous to `clk`. They also assume that a suspend command never lands in the same cycle as the end of a resume delay, since that collision is excluded from the resume-exit property. The stimulus drives every input on the falling clock edge and sends commands one at a time. Before it issues a new command, it waits for each timed sequence to finish or brings it to an end on purpose. Ticks are single-cycle pulses separated by idle cycles, and `cs_n` is held high except in the cycles where a wake-up is meant to be tested.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned B_CLK_KEEP = 7;
  localparam int unsigned B_RESUME   = 6;
  localparam int unsigned B_SUSPEND  = 5;
  localparam int unsigned B_SRST     = 4;
  localparam int unsigned B_IRQ_EN   = 3;
  localparam int unsigned B_WAKE_EN  = 2;
  localparam int unsigned B_RSVD     = 1;
  localparam int unsigned B_PULLUP   = 0;

  localparam logic [REG_W-1:0] CMD_MASK  = 8'b0111_0000;
  localparam logic [REG_W-1:0] KEEP_MASK = 8'b1000_1001;
  localparam logic [REG_W-1:0] RSVD_MASK = 8'b0000_0010;

  // Bits whose stored one is overwritten by a zero on this write
  function automatic logic [REG_W-1:0] fire_mask(input logic [REG_W-1:0] held,
                                                 input logic [REG_W-1:0] wbyte);
    return held & ~wbyte & CMD_MASK;
  endfunction

  // Value left after a USB bus reset
  function automatic logic [REG_W-1:0] bus_reset_keep(input logic [REG_W-1:0] held);
    return held & KEEP_MASK;
  endfunction

  // Value actually stored from a written byte
  function automatic logic [REG_W-1:0] sanitize(input logic [REG_W-1:0] wbyte);
    return wbyte & ~RSVD_MASK;
  endfunction
endpackage

// File: rtl/pm_ms_timer.sv
module pm_ms_timer #(
  parameter int unsigned TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);

  logic [CW-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign done = busy && tick && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr)          cnt_q <= '0;
    else if (start)        cnt_q <= LOAD;
    else if (busy && tick) cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             bus_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_byte,
  output logic [REG_W-1:0] ctrl,
  output logic             resume_fire,
  output logic             suspend_fire,
  output logic             srst_fire
);
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] fired;
  logic             wr_ok;

  assign wr_ok = wr_en && !srst && !bus_rst;
  assign fired = wr_ok ? fire_mask(ctrl_q, wr_byte) : '0;

  assign resume_fire  = fired[B_RESUME];
  assign suspend_fire = fired[B_SUSPEND];
  assign srst_fire    = fired[B_SRST];
  assign ctrl         = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (srst)    ctrl_q <= '0;
    else if (bus_rst) ctrl_q <= bus_reset_keep(ctrl_q);
    else if (wr_en)   ctrl_q <= sanitize(wr_byte);
  end
endmodule

// File: rtl/pm_power_seq.sv
module pm_power_seq #(
  parameter int unsigned GATE_MS      = 2,
  parameter int unsigned RES_DELAY_MS = 5,
  parameter int unsigned RES_DRIVE_MS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic suspend_fire,
  input  logic resume_fire,
  input  logic clk_keep,
  input  logic wake_en,
  input  logic cs_n,
  output logic suspended,
  output logic clk_en,
  output logic resume_drive,
  output logic wake_evt,
  output logic gate_evt,
  output logic res_start_evt,
  output logic res_end_evt
);
  logic susp_q, gated_q, drive_q, wake_q;
  logic wake_hit, leave;
  logic gate_busy, dly_busy, drv_busy;

  assign wake_hit = susp_q && wake_en && !cs_n;
  assign leave    = wake_hit || res_start_evt;

  pm_ms_timer #(.TICKS(GATE_MS)) u_gate_tmr (
    .clk(clk), .rst_n(rst_n), .clr(clr || leave), .start(suspend_fire),
    .tick(tick), .busy(gate_busy), .done(gate_evt));

  pm_ms_timer #(.TICKS(RES_DELAY_MS)) u_dly_tmr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(resume_fire),
    .tick(tick), .busy(dly_busy), .done(res_start_evt));

  pm_ms_timer #(.TICKS(RES_DRIVE_MS)) u_drv_tmr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(res_start_evt),
    .tick(tick), .busy(drv_busy), .done(res_end_evt));

  logic unused_busy;
  assign unused_busy = gate_busy ^ dly_busy ^ drv_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q  <= 1'b0;
      gated_q <= 1'b0;
      drive_q <= 1'b0;
      wake_q  <= 1'b0;
    end else if (clr) begin
      susp_q  <= 1'b0;
      gated_q <= 1'b0;
      drive_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= wake_hit;
      if (suspend_fire)    susp_q <= 1'b1;
      else if (leave)      susp_q <= 1'b0;
      if (leave)           gated_q <= 1'b0;
      else if (gate_evt && susp_q) gated_q <= 1'b1;
      if (res_start_evt)   drive_q <= 1'b1;
      else if (res_end_evt) drive_q <= 1'b0;
    end
  end

  assign suspended    = susp_q;
  assign clk_en       = !(gated_q && !clk_keep);
  assign resume_drive = drive_q;
  assign wake_evt     = wake_q;
endmodule

// File: rtl/usb_pwr_mode_reg.sv
module usb_pwr_mode_reg #(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned GATE_MS      = 2,
  parameter int unsigned RES_DELAY_MS = 5,
  parameter int unsigned RES_DRIVE_MS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              cs_n,
  input  logic              ms_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              clk_en,
  output logic              suspended,
  output logic              resume_drive,
  output logic              soft_rst_pulse,
  output logic              irq_en,
  output logic              pullup_en,
  output logic              wake_evt
);
  import pm_pkg::*;

  logic [REG_W-1:0] ctrl;
  logic resume_fire, suspend_fire, srst_fire;
  logic srst_q;
  logic gate_evt, res_start_evt, res_end_evt;

  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:REG_W];

  pm_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .srst(srst_q), .bus_rst(bus_rst),
    .wr_en(wr_en), .wr_byte(wr_data[REG_W-1:0]), .ctrl(ctrl),
    .resume_fire(resume_fire), .suspend_fire(suspend_fire),
    .srst_fire(srst_fire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= srst_fire;
  end

  pm_power_seq #(
    .GATE_MS(GATE_MS), .RES_DELAY_MS(RES_DELAY_MS), .RES_DRIVE_MS(RES_DRIVE_MS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(srst_q || bus_rst), .tick(ms_tick),
    .suspend_fire(suspend_fire), .resume_fire(resume_fire),
    .clk_keep(ctrl[B_CLK_KEEP]), .wake_en(ctrl[B_WAKE_EN]), .cs_n(cs_n),
    .suspended(suspended), .clk_en(clk_en), .resume_drive(resume_drive),
    .wake_evt(wake_evt), .gate_evt(gate_evt), .res_start_evt(res_start_evt),
    .res_end_evt(res_end_evt));

  always_comb begin
    rd_data = '0;
    if (rd_en) rd_data[REG_W-1:0] = ctrl & ~RSVD_MASK;
  end

  assign soft_rst_pulse = srst_q;
  assign irq_en         = ctrl[B_IRQ_EN];
  assign pullup_en      = ctrl[B_PULLUP];
endmodule

// File: rtl/pm_checks.sv
module pm_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rst,
  input logic        cs_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        rd_en,
  input logic [15:0] rd_data,
  input logic        clk_en,
  input logic        suspended,
  input logic        resume_drive,
  input logic        soft_rst_pulse,
  input logic        irq_en,
  input logic        pullup_en,
  input logic        wake_evt,
  input logic        suspend_fire,
  input logic        res_start_evt
);
  assert_read_format_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_data[15:8] == 8'h00 && !rd_data[1]));

  assert_cmd_needs_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_fire |-> (wr_en && !wr_data[5]));

  assert_suspend_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_fire |=> suspended);

  assert_gate_in_suspend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> suspended);

  assert_resume_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_start_evt && !suspend_fire && !bus_rst && !soft_rst_pulse)
      |=> (resume_drive && !suspended && clk_en));

  assert_wake_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> $past(suspended && !cs_n));

  assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !wake_evt);

  assert_bus_reset_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && !soft_rst_pulse)
      |=> (irq_en == $past(irq_en) && pullup_en == $past(pullup_en)
           && !suspended && !resume_drive));

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> (!soft_rst_pulse && !irq_en && !pullup_en
                        && !suspended && !resume_drive && clk_en));
endmodule

bind usb_pwr_mode_reg pm_checks u_pm_checks (.*);

// File: tb/test_usb_pwr_mode_reg.sv
`timescale 1ns/1ps
module test_usb_pwr_mode_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst = 1'b0;
  logic        cs_n = 1'b1;
  logic        ms_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        clk_en, suspended, resume_drive, soft_rst_pulse;
  logic        irq_en, pullup_en, wake_evt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  usb_pwr_mode_reg #(.GATE_MS(2), .RES_DELAY_MS(3), .RES_DRIVE_MS(4)) i_usb_pwr_mode_reg (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .cs_n(cs_n), .ms_tick(ms_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .clk_en(clk_en), .suspended(suspended), .resume_drive(resume_drive),
    .soft_rst_pulse(soft_rst_pulse), .irq_en(irq_en), .pullup_en(pullup_en),
    .wake_evt(wake_evt));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when a read is on the bus
  always @(posedge clk) begin
    #1;
    if (rd_en) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected read actual=%h expected=none", rd_data);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_expect(input logic [15:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 clk_en", {15'd0, clk_en}, 16'd1);
    chk("R1 idle outputs", {9'd0, suspended, resume_drive, soft_rst_pulse,
        irq_en, pullup_en, wake_evt, 1'b0}, 16'd0);
    rd_expect(16'h0000, "R1 read after reset");

    // R2 upper byte ignored, bit1 reads zero; R10 enables
    wr(16'hFF8F);
    rd_expect(16'h008D, "R2 read format");
    chk("R10 irq_en/pullup_en", {14'd0, irq_en, pullup_en}, 16'h0003);

    // R8 bus reset keeps 7,3,0
    wr(16'h00CD);
    pulse_bus_rst();
    rd_expect(16'h0089, "R8 bus reset keep mask");

    // R3 zero over zero and a one do nothing
    wr(16'h0089);
    @(negedge clk);
    chk("R3 zero-over-zero", {15'd0, suspended}, 16'd0);
    wr(16'h00A9);
    @(negedge clk);
    chk("R3 write of one", {15'd0, suspended}, 16'd0);
    // R4 suspend entry
    wr(16'h0089);
    chk("R4 suspended", {15'd0, suspended}, 16'd1);

    // R5 clock kept on with bit 7 set
    tick_n(3);
    chk("R5 clock keep", {15'd0, clk_en}, 16'd1);

    // R7 wake disabled: no effect
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 wake disabled", {14'd0, suspended, wake_evt}, 16'b10);
    cs_n = 1'b1;
    wr(16'h008D);
    @(negedge clk); cs_n = 1'b0;
    @(posedge clk); #1;
    chk("R7 wake pulse", {14'd0, wake_evt, suspended}, 16'b10);
    @(negedge clk); cs_n = 1'b1;
    @(posedge clk); #1;
    chk("R7 wake single cycle", {15'd0, wake_evt}, 16'd0);

    // R5 gating with bit 7 clear
    wr(16'h002D);
    wr(16'h000D);
    tick_n(1);
    chk("R5 clk before gate", {15'd0, clk_en}, 16'd1);
    tick_n(1);
    chk("R5 clk gated", {15'd0, clk_en}, 16'd0);

    // R6 resume timing
    wr(16'h004D);
    wr(16'h000D);
    tick_n(2);
    chk("R6 during delay", {13'd0, resume_drive, suspended, clk_en}, 16'b010);
    tick_n(1);
    chk("R6 drive start", {13'd0, resume_drive, suspended, clk_en}, 16'b101);
    tick_n(3);
    chk("R6 drive held", {15'd0, resume_drive}, 16'd1);
    tick_n(1);
    chk("R6 drive end", {15'd0, resume_drive}, 16'd0);

    // R8 bus reset ends suspend
    wr(16'h002D);
    wr(16'h000D);
    chk("R8 suspended before bus reset", {15'd0, suspended}, 16'd1);
    pulse_bus_rst();
    chk("R8 suspend ended", {15'd0, suspended}, 16'd0);
    rd_expect(16'h0009, "R8 read after bus reset");

    // R9 soft reset
    wr(16'h0019);
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h0009;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    chk("R9 pulse high", {15'd0, soft_rst_pulse}, 16'd1);
    @(negedge clk);
    chk("R9 pulse one cycle", {15'd0, soft_rst_pulse}, 16'd0);
    chk("R9 enables cleared", {14'd0, irq_en, pullup_en}, 16'd0);
    rd_expect(16'h0000, "R9 read after soft reset");

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", 16'(exp_q.size()), 16'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule